// File: doc/BRIEF.md
# Serial Command Slave with Status Return

This block is the control port of a record/playback engine. A host drives a four-wire serial link into it: an active-low select, a serial clock, a data input and a data output. Each instruction is a 24-bit frame, sent least significant bit first. The frame holds a 16-bit row address and an 8-bit control field. In the same frame the block shifts back two status flags and the engine's current 16-bit row pointer. The host can therefore read status and issue a new command in a single transfer.

All four link signals are asynchronous to the system clock. The block resamples them through multi-flop synchronisers and finds the serial clock and select edges in the system clock domain. A frame becomes a command only when select returns high after exactly 24 sampled bits. The command then appears as a one-cycle strobe with decoded fields for the engine: address load, power, play or record, run or stop, and message cueing.

The block also latches the overflow and end-of-message events that the engine reports, and drives an active-low interrupt from them. The interrupt is cleared as soon as the next frame begins.

Top module: `cmdlink_slave`

## Requirements
- R1: After reset, `int_n` is 1, `miso_oe` is 0 and `cmd_valid` is 0.
- R2: `miso_oe` is 1 while the synchronised select is low and 0 while it is high.
- R3: Input bits are taken on rising serial clock edges, first bit first. Frame bits 0-15 are the address (bit 0 first), bit 16 is cue, bit 17 is keep-address, bit 18 is power (1 = up), bit 19 is play (1 = play, 0 = record), bit 20 is run (1 = start), and bits 21-23 are ignored. `cmd_power`, `cmd_play` and `cmd_run` copy bits 18, 19 and 20.
- R4: On the select falling edge the output word {6 zeros, row_ptr, eom flag, ovf flag} is captured. Its bit 0 (overflow) is on `miso` before the first rising serial clock edge. The word advances one bit on each falling serial clock edge, so the order is overflow, end-of-message, P0..P15, then zeros.
- R5: `cmd_valid` is a single-cycle pulse that occurs only after select has risen, and never while select is low.
- R6: A frame that did not contain exactly 24 rising serial clock edges produces no command.
- R7: `cmd_load` is 1 exactly when keep-address is 0 and run is 1. `cmd_addr` carries frame bits 0-15.
- R8: `cmd_cue` is 1 only when cue, play and run are all 1 and `eng_busy` is 0. Otherwise it is 0.
- R9: A one-cycle pulse on `ovf_evt` or `eom_evt` drives `int_n` low, and `int_n` stays low until the next select falling edge.
- R10: The select falling edge clears both latched flags and releases `int_n`. The flags captured into the output word at that edge are the values from before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| sel_n | input | 1 | Active-low frame select (asynchronous) |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status data to host |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| int_n | output | 1 | Active-low interrupt |
| row_ptr | input | 16 | Engine's current row pointer |
| ovf_evt | input | 1 | Engine pulse: operation ended on overflow |
| eom_evt | input | 1 | Engine pulse: operation ended on end-of-message |
| eng_busy | input | 1 | Engine is running an operation |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | 16 | Row address from the frame |
| cmd_load | output | 1 | Load the row pointer from `cmd_addr` |
| cmd_power | output | 1 | 1 = power up, 0 = power down |
| cmd_play | output | 1 | 1 = play, 0 = record |
| cmd_run | output | 1 | 1 = start, 0 = stop |
| cmd_cue | output | 1 | Message cueing accepted |

## Verification
Frames are sent with the control field set as a positioned play with address load, a record that keeps the current row, a stop, and three cue requests. The cue requests separate the engine-idle play case from a busy engine and from a record. Together these patterns show that each control bit lands on its own output, and that the spare bits change nothing. A fixed, asymmetric row pointer and flag events of each kind are read back in the returned word, which exposes any bit-order or bit-position error. Frames of 10 and 26 clock edges check that only an exact-length frame becomes a command.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

    localparam int ADDR_W  = 16;
    localparam int CTRL_W  = 8;
    localparam int FLAG_W  = 2;
    localparam int FRAME_W = ADDR_W + CTRL_W;
    localparam int PAD_W   = FRAME_W - ADDR_W - FLAG_W;

    // Control byte, bit 0 is the first control bit on the wire.
    typedef struct packed {
        logic [2:0] spare;
        logic       run;
        logic       play;
        logic       power;
        logic       keep_addr;
        logic       cue;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              load;
        logic              power;
        logic              play;
        logic              run;
        logic              cue;
    } cmd_t;

    typedef struct packed {
        logic eom;
        logic ovf;
    } flags_t;

    function automatic cmd_t decode_frame(input logic [FRAME_W-1:0] f,
                                          input logic busy);
        ctrl_t c;
        cmd_t  r;
        c       = ctrl_t'(f[FRAME_W-1 -: CTRL_W]);
        r.addr  = f[ADDR_W-1:0];
        r.load  = ~c.keep_addr & c.run;
        r.power = c.power;
        r.play  = c.play;
        r.run   = c.run;
        r.cue   = c.cue & c.play & c.run & ~busy;
        return r;
    endfunction

    function automatic logic [FRAME_W-1:0] status_word(input logic [ADDR_W-1:0] ptr,
                                                       input flags_t fl);
        return {{PAD_W{1'b0}}, ptr, fl};
    endfunction

endpackage

// File: rtl/cmdlink_sync.sv
module cmdlink_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {STAGES{INIT}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                pipe[s] <= pipe[s-1];
            end
            pipe[0] <= d_async;
        end
    end

    assign d_sync = pipe[STAGES-1];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/cmdlink_shift.sv
module cmdlink_shift
    import cmdlink_pkg::*;
#(
    parameter int N = FRAME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         selected,
    input  logic         sel_fall,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         din,
    input  logic [N-1:0] snapshot,
    output logic [N-1:0] rx_word,
    output logic         rx_full,
    output logic         dout
);
    localparam int LIM   = N + 1;
    localparam int CNT_W = $clog2(LIM + 1);

    logic [N-1:0]     rx_q;
    logic [N-1:0]     tx_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q  <= '0;
            tx_q  <= '0;
            cnt_q <= '0;
        end else if (sel_fall) begin
            tx_q  <= snapshot;
            cnt_q <= '0;
        end else if (selected) begin
            if (sclk_rise) begin
                rx_q <= {din, rx_q[N-1:1]};
                if (cnt_q != CNT_W'(LIM)) cnt_q <= cnt_q + 1'b1;
            end
            if (sclk_fall) begin
                tx_q <= {1'b0, tx_q[N-1:1]};
            end
        end
    end

    assign rx_word = rx_q;
    assign rx_full = (cnt_q == CNT_W'(N));
    assign dout    = tx_q[0];

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(LIM));

    // R4
    snap_load_chk: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> dout == $past(snapshot[0]));
endmodule

// File: rtl/cmdlink_status.sv
module cmdlink_status
    import cmdlink_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_fall,
    input  logic   ovf_evt,
    input  logic   eom_evt,
    output flags_t flags,
    output logic   int_n
);
    flags_t fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q.ovf <= ovf_evt | (fl_q.ovf & ~sel_fall);
            fl_q.eom <= eom_evt | (fl_q.eom & ~sel_fall);
        end
    end

    assign flags = fl_q;
    assign int_n = ~(fl_q.ovf | fl_q.eom);

    // R9
    int_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt || eom_evt) |=> !int_n);

    // R10
    int_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_fall && !ovf_evt && !eom_evt) |=> int_n);
endmodule

// File: rtl/cmdlink_slave.sv
module cmdlink_slave
    import cmdlink_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sel_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              int_n,
    input  logic [ADDR_W-1:0] row_ptr,
    input  logic              ovf_evt,
    input  logic              eom_evt,
    input  logic              eng_busy,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_load,
    output logic              cmd_power,
    output logic              cmd_play,
    output logic              cmd_run,
    output logic              cmd_cue
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw, synced;
    logic             sclk_s, sel_s, mosi_s;
    logic             sclk_last, sel_last;
    logic             sclk_rise, sclk_fall, sel_rise, sel_fall, selected;
    logic [FRAME_W-1:0] rx_word;
    logic             rx_full;
    flags_t           flags;
    cmd_t             cmd_q;
    logic             valid_q;

    assign raw = {mosi, sel_n, sclk};

    cmdlink_sync #(.W(LINES), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw),
        .d_sync  (synced)
    );

    assign sclk_s = synced[0];
    assign sel_s  = synced[1];
    assign mosi_s = synced[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_last <= 1'b0;
            sel_last  <= 1'b1;
        end else begin
            sclk_last <= sclk_s;
            sel_last  <= sel_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_last;
    assign sclk_fall = ~sclk_s & sclk_last;
    assign sel_rise  = sel_s & ~sel_last;
    assign sel_fall  = ~sel_s & sel_last;
    assign selected  = ~sel_s;

    cmdlink_status u_status (
        .clk      (clk),
        .rst      (rst),
        .sel_fall (sel_fall),
        .ovf_evt  (ovf_evt),
        .eom_evt  (eom_evt),
        .flags    (flags),
        .int_n    (int_n)
    );

    cmdlink_shift #(.N(FRAME_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .selected  (selected),
        .sel_fall  (sel_fall),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (mosi_s),
        .snapshot  (status_word(row_ptr, flags)),
        .rx_word   (rx_word),
        .rx_full   (rx_full),
        .dout      (miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= sel_rise & rx_full;
            if (sel_rise && rx_full) cmd_q <= decode_frame(rx_word, eng_busy);
        end
    end

    assign miso_oe   = selected;
    assign cmd_valid = valid_q;
    assign cmd_addr  = cmd_q.addr;
    assign cmd_load  = cmd_q.load;
    assign cmd_power = cmd_q.power;
    assign cmd_play  = cmd_q.play;
    assign cmd_run   = cmd_q.run;
    assign cmd_cue   = cmd_q.cue;

    // R5
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R5
    cmd_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !miso_oe);

    // R8
    cue_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_cue) |-> (cmd_play && cmd_run && !$past(eng_busy)));
endmodule

// File: tb/sim_cmdlink_slave.sv
module sim_cmdlink_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe, int_n;
    logic [15:0] row_ptr = 16'hA5C3;
    logic        ovf_evt = 1'b0, eom_evt = 1'b0, eng_busy = 1'b0;
    logic        cmd_valid, cmd_load, cmd_power, cmd_play, cmd_run, cmd_cue;
    logic [15:0] cmd_addr;

    int errors = 0, checks = 0, ncmd = 0, bad_sel = 0;
    logic [15:0] l_addr;
    logic        l_load, l_power, l_play, l_run, l_cue;
    logic        int_mid, oe_mid;
    logic [23:0] rsp;
    bit          done = 0;

    always #10 clk = ~clk;

    cmdlink_slave u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .sel_n(sel_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .int_n(int_n), .row_ptr(row_ptr),
        .ovf_evt(ovf_evt), .eom_evt(eom_evt), .eng_busy(eng_busy),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_load(cmd_load),
        .cmd_power(cmd_power), .cmd_play(cmd_play), .cmd_run(cmd_run),
        .cmd_cue(cmd_cue)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            ncmd++;
            if (!sel_n) bad_sel++;
            l_addr = cmd_addr; l_load = cmd_load; l_power = cmd_power;
            l_play = cmd_play; l_run = cmd_run; l_cue = cmd_cue;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] mk(input logic [15:0] a, input logic cue,
                                       input logic keep, input logic pu,
                                       input logic pl, input logic run);
        return {3'b101, run, pl, pu, keep, cue, a};
    endfunction

    task automatic frame(input logic [23:0] din, input int nbits);
        rsp = '0;
        sel_n = 1'b0;
        waitc(8);
        int_mid = int_n;
        oe_mid  = miso_oe;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? din[i] : 1'b1;
            waitc(4);
            if (i < 24) rsp[i] = miso;
            sclk = 1'b1;
            waitc(8);
            sclk = 1'b0;
            waitc(4);
        end
        sel_n = 1'b1;
        waitc(12);
    endtask

    task automatic t_reset();
        chk("R1 int_n", int_n, 1);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 cmd count", ncmd, 0);
    endtask

    task automatic t_setplay();
        int n0 = ncmd;
        frame(mk(16'h1234, 0, 0, 1, 1, 1), 24);
        chk("R2 oe while selected", oe_mid, 1);
        chk("R2 oe released", miso_oe, 0);
        chk("R5 one command", ncmd, n0 + 1);
        chk("R7 addr", l_addr, 16'h1234);
        chk("R7 load", l_load, 1);
        chk("R3 power/play/run", {l_power, l_play, l_run}, 3'b111);
        chk("R8 no cue requested", l_cue, 0);
        chk("R4 status word", rsp, {6'b0, 16'hA5C3, 2'b00});
    endtask

    task automatic t_rec_keep();
        frame(mk(16'hFFFF, 0, 1, 1, 0, 1), 24);
        chk("R7 keep-address no load", l_load, 0);
        chk("R3 record", {l_power, l_play, l_run}, 3'b101);
        frame(mk(16'h0001, 0, 0, 0, 1, 0), 24);
        chk("R7 stop no load", l_load, 0);
        chk("R3 stop power down", {l_power, l_play, l_run}, 3'b010);
        chk("R7 addr passes", l_addr, 16'h0001);
    endtask

    task automatic t_cue();
        eng_busy = 1'b0;
        frame(mk(16'h0040, 1, 0, 1, 1, 1), 24);
        chk("R8 cue idle play", l_cue, 1);
        eng_busy = 1'b1;
        frame(mk(16'h0040, 1, 1, 1, 1, 1), 24);
        chk("R8 cue busy", l_cue, 0);
        eng_busy = 1'b0;
        frame(mk(16'h0040, 1, 0, 1, 0, 1), 24);
        chk("R8 cue record", l_cue, 0);
    endtask

    task automatic t_length();
        int n0 = ncmd;
        frame(mk(16'h2222, 0, 0, 1, 1, 1), 10);
        chk("R6 short frame", ncmd, n0);
        frame(mk(16'h3333, 0, 0, 1, 1, 1), 26);
        chk("R6 long frame", ncmd, n0);
    endtask

    task automatic t_int();
        ovf_evt = 1'b1; waitc(1); ovf_evt = 1'b0;
        waitc(2);
        chk("R9 int set", int_n, 0);
        waitc(50);
        chk("R9 int held", int_n, 0);
        frame(mk(16'h0, 0, 1, 1, 1, 0), 24);
        chk("R10 int cleared at frame start", int_mid, 1);
        chk("R10 ovf returned", rsp[1:0], 2'b01);
        eom_evt = 1'b1; waitc(1); eom_evt = 1'b0;
        waitc(2);
        chk("R9 int set eom", int_n, 0);
        row_ptr = 16'h0F01;
        frame(mk(16'h0, 0, 1, 1, 1, 0), 24);
        chk("R10 eom returned", rsp, {6'b0, 16'h0F01, 2'b10});
        chk("R10 int released", int_n, 1);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(5);
        t_reset();
        t_setplay();
        t_rec_keep();
        t_cue();
        t_length();
        t_int();
        chk("R5 no command while selected", bad_sel, 0);
        done = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end
endmodule